// File: doc/BRIEF.md
# Edge-Aligned PWM Timer Channel

This block is a 16-bit up-counter with a single edge-aligned pulse-width channel. Software programs it through a byte-wide register bus. The counter runs from zero up to a programmed period limit and then returns to zero. The channel pin is in its active level while the count is below the programmed duty value, and in its inactive level for the rest of the period. Two sticky flags are provided: one for the compare event and one for the counter wrap.

Both 16-bit values (period limit and duty) are written as two bytes. Each byte pair is gathered in a staging latch and promoted only when both halves have arrived. While the counter runs, a promoted value becomes active only at the next period boundary, so a period in progress always finishes with the settings it started with. While the clock select field is zero, the counter and the pin are frozen and staged values become active at once. Writing the control register while the debug input is high drops any half-written period value.

The bus is a plain register port with no back-pressure. A write completes in the cycle `bus_wr` is high. Read data is combinational from `bus_addr`, and the read strobe `bus_rd` only matters for arming flag clears.

Top module: `pwm_timer_ch`

## Requirements
- R1: After reset `pwm_out`, `ch_flag` and `ovf_flag` are 0, the control and channel control registers read 0x00, the period limit reads 0xFFFF, and the duty reads 0x0000.
- R2: When the clock select field is nonzero, the counter advances by one every clock. When it equals the period limit, it wraps to 0 on the next clock. A limit of 7 gives an 8-cycle period.
- R3: A nonzero duty value written while the counter runs first applies in the period that follows the next wrap. The rest of the current period keeps the old duty.
- R4: Changing the duty from nonzero to zero lets the current period finish with the old duty. Output is 0% from the next period on.
- R5: While control bits [1:0] are 00, the counter and `pwm_out` hold their values. A channel control write in that state does not change `pwm_out` until the clock is selected again.
- R6: Register map: 0 control, 1/2 period limit high/low, 3 channel control, 4/5 duty high/low, 6/7 counter high/low (read only).
  - A 16-bit value is staged only after both of its bytes are written, in either order.
  - Reads of 1/2 and 4/5 return the active values.
  - With the clock stopped, a staged value becomes active one cycle after its second byte.
- R7: A control write while `dbg_mode` is 1 discards a half-written period limit. The next byte written then only starts a new pair.
- R8: Channel control bits [5:4] = 10 select edge-aligned PWM, and bits [3:2] pick the polarity.
  - With polarity 10, `pwm_out` is 1 while the count is below the duty and 0 otherwise.
  - With polarity x1 the levels are inverted.
  - With polarity 00 or any other mode, the pin drives 0.
  - The pin changes only on clocks where the counter advances.
- R9: A duty of 0 gives a constant inactive level. A duty greater than the period limit gives a constant active level.
- R10: Channel control bit 7 (`ch_flag`) sets when the counter steps onto the duty value. It clears only on a channel control write with bit 7 = 0 that follows a read of that register made while the flag was set.
- R11: Control bit 7 (`ovf_flag`) sets when the counter wraps. It uses the same read-then-write-0 clearing rule on the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_mode | input | 1 | Debug state; makes a control write drop a half-written period limit |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, arms flag clearing |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pwm_out | output | 1 | PWM pin |
| ch_flag | output | 1 | Compare flag |
| ovf_flag | output | 1 | Wrap flag |

## Verification
The bench rewrites the duty in the middle of a period and checks that the rest of that period keeps the old level. A design that applied the new duty at once would drop the pin early. It also checks that changing the duty to zero still lets the current period end high, where an eager design would truncate the pulse. It stops the clock while the pin is high and changes polarity in that state, where a leaky design would flip the pin before the clock returns. It splits a period write around a debug-mode control write, where a design that kept the stale half would install a mixed value. Flag clearing is tried without the arming read, and random periods, duties and polarities are compared against a bench model of the output level.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [2:0] {
    A_CTRL    = 3'd0,
    A_LIM_HI  = 3'd1,
    A_LIM_LO  = 3'd2,
    A_CHCTL   = 3'd3,
    A_DUTY_HI = 3'd4,
    A_DUTY_LO = 3'd5,
    A_CNT_HI  = 3'd6,
    A_CNT_LO  = 3'd7
  } reg_addr_e;

  localparam logic [1:0] MODE_EDGE_PWM = 2'b10;
  localparam logic [1:0] CLK_OFF       = 2'b00;
endpackage

// File: rtl/pwm_pair_stage.sv
module pwm_pair_stage #(
  parameter int DATA_W = 8,
  localparam int FULL_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drop_half,
  input  logic              take,
  output logic [FULL_W-1:0] staged_val,
  output logic              staged_v
);
  logic [DATA_W-1:0] hi_buf, lo_buf;
  logic              hi_seen, lo_seen;
  logic              pair_done;

  assign pair_done = (wr_hi && (lo_seen || wr_lo)) || (wr_lo && hi_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_buf     <= '0;
      lo_buf     <= '0;
      hi_seen    <= 1'b0;
      lo_seen    <= 1'b0;
      staged_val <= '0;
      staged_v   <= 1'b0;
    end else begin
      if (wr_hi) hi_buf <= wdata;
      if (wr_lo) lo_buf <= wdata;
      if (pair_done || drop_half) begin
        hi_seen <= 1'b0;
        lo_seen <= 1'b0;
      end else begin
        if (wr_hi) hi_seen <= 1'b1;
        if (wr_lo) lo_seen <= 1'b1;
      end
      if (pair_done) begin
        staged_val <= {(wr_hi ? wdata : hi_buf), (wr_lo ? wdata : lo_buf)};
        staged_v   <= 1'b1;
      end else if (take) begin
        staged_v   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] LIM_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] lim_staged,
  input  logic             lim_sv,
  input  logic [CNT_W-1:0] duty_staged,
  input  logic             duty_sv,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] lim_act,
  output logic [CNT_W-1:0] duty_act,
  output logic             wrap,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] duty_eff,
  output logic             lim_take,
  output logic             duty_take
);
  logic boundary;

  assign wrap      = run && (cnt_q >= lim_act);
  assign cnt_nxt   = wrap ? '0 : CNT_W'(cnt_q + 1'b1);
  assign boundary  = wrap || !run;
  assign lim_take  = boundary && lim_sv;
  assign duty_take = boundary && duty_sv;
  assign duty_eff  = (wrap && duty_sv) ? duty_staged : duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      lim_act  <= LIM_RST;
      duty_act <= '0;
    end else begin
      if (run)       cnt_q    <= cnt_nxt;
      if (lim_take)  lim_act  <= lim_staged;
      if (duty_take) duty_act <= duty_staged;
    end
  end
endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] duty_eff,
  input  logic [1:0]       mode,
  input  logic [1:0]       pol,
  output logic             pin_q,
  output logic             match
);
  logic in_active;
  logic enabled;

  assign match     = tick && (cnt_nxt == duty_eff);
  assign in_active = cnt_nxt < duty_eff;
  assign enabled   = (mode == MODE_EDGE_PWM) && (pol != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pin_q <= 1'b0;
    else if (tick) pin_q <= enabled ? (pol[0] ? ~in_active : in_active) : 1'b0;
  end
endmodule

// File: rtl/pwm_sticky_flag.sv
module pwm_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic rd_reg,
  input  logic wr_reg,
  input  logic wr_bit,
  output logic flag_q
);
  logic armed_q;
  logic clear;

  assign clear = wr_reg && !wr_bit && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set)        flag_q <= 1'b1;
      else if (clear) flag_q <= 1'b0;
      if (wr_reg)                armed_q <= 1'b0;
      else if (rd_reg && flag_q) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_timer_ch.sv
module pwm_timer_ch
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_mode,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out,
  output logic              ch_flag,
  output logic              ovf_flag
);
  logic [1:0] clk_sel_q, mode_q, pol_q;
  logic       run;
  logic [CNT_W-1:0] lim_staged, duty_staged, cnt_q, lim_act, duty_act, cnt_nxt, duty_eff;
  logic       lim_sv, duty_sv, lim_take, duty_take, wrap, match;
  logic       wr_ctrl, wr_chctl;

  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_chctl = bus_wr && (bus_addr == A_CHCTL);
  assign run      = (clk_sel_q != CLK_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel_q <= CLK_OFF;
      mode_q    <= 2'b00;
      pol_q     <= 2'b00;
    end else begin
      if (wr_ctrl) clk_sel_q <= bus_wdata[1:0];
      if (wr_chctl) begin
        mode_q <= bus_wdata[5:4];
        pol_q  <= bus_wdata[3:2];
      end
    end
  end

  pwm_pair_stage #(.DATA_W(DATA_W)) lim_stage_i (
    .clk(clk), .rst_n(rst_n),
    .wr_hi(bus_wr && bus_addr == A_LIM_HI), .wr_lo(bus_wr && bus_addr == A_LIM_LO),
    .wdata(bus_wdata), .drop_half(wr_ctrl && dbg_mode), .take(lim_take),
    .staged_val(lim_staged), .staged_v(lim_sv)
  );

  pwm_pair_stage #(.DATA_W(DATA_W)) duty_stage_i (
    .clk(clk), .rst_n(rst_n),
    .wr_hi(bus_wr && bus_addr == A_DUTY_HI), .wr_lo(bus_wr && bus_addr == A_DUTY_LO),
    .wdata(bus_wdata), .drop_half(1'b0), .take(duty_take),
    .staged_val(duty_staged), .staged_v(duty_sv)
  );

  pwm_count_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .lim_staged(lim_staged), .lim_sv(lim_sv),
    .duty_staged(duty_staged), .duty_sv(duty_sv),
    .cnt_q(cnt_q), .lim_act(lim_act), .duty_act(duty_act),
    .wrap(wrap), .cnt_nxt(cnt_nxt), .duty_eff(duty_eff),
    .lim_take(lim_take), .duty_take(duty_take)
  );

  pwm_chan_out #(.CNT_W(CNT_W)) out_i (
    .clk(clk), .rst_n(rst_n), .tick(run), .cnt_nxt(cnt_nxt), .duty_eff(duty_eff),
    .mode(mode_q), .pol(pol_q), .pin_q(pwm_out), .match(match)
  );

  pwm_sticky_flag ovf_flag_i (
    .clk(clk), .rst_n(rst_n), .set(wrap),
    .rd_reg(bus_rd && bus_addr == A_CTRL), .wr_reg(wr_ctrl),
    .wr_bit(bus_wdata[DATA_W-1]), .flag_q(ovf_flag)
  );

  pwm_sticky_flag ch_flag_i (
    .clk(clk), .rst_n(rst_n), .set(match),
    .rd_reg(bus_rd && bus_addr == A_CHCTL), .wr_reg(wr_chctl),
    .wr_bit(bus_wdata[DATA_W-1]), .flag_q(ch_flag)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:    bus_rdata = {ovf_flag, {(DATA_W-3){1'b0}}, clk_sel_q};
      A_LIM_HI:  bus_rdata = lim_act[CNT_W-1:DATA_W];
      A_LIM_LO:  bus_rdata = lim_act[DATA_W-1:0];
      A_CHCTL:   bus_rdata = {ch_flag, {(DATA_W-7){1'b0}}, mode_q, pol_q, 2'b00};
      A_DUTY_HI: bus_rdata = duty_act[CNT_W-1:DATA_W];
      A_DUTY_LO: bus_rdata = duty_act[DATA_W-1:0];
      A_CNT_HI:  bus_rdata = cnt_q[CNT_W-1:DATA_W];
      default:   bus_rdata = cnt_q[DATA_W-1:0];
    endcase
  end
endmodule

// File: rtl/pwm_timer_ch_chk.sv
module pwm_timer_ch_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             wrap,
  input logic             match,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] duty_act,
  input logic             pwm_out,
  input logic             ch_flag,
  input logic             ovf_flag
);
  assert_pin_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pwm_out));
  assert_count_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));
  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
  assert_duty_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(duty_act));
  assert_ovf_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);
  assert_match_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> ch_flag);
endmodule

bind pwm_timer_ch pwm_timer_ch_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .wrap(wrap), .match(match),
  .cnt_q(cnt_q), .duty_act(duty_act), .pwm_out(pwm_out),
  .ch_flag(ch_flag), .ovf_flag(ovf_flag)
);

// File: tb/pwm_timer_ch_tb.sv
`timescale 1ns/1ps
module pwm_timer_ch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dbg_mode = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       pwm_out, ch_flag, ovf_flag;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_timer_ch dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .ch_flag(ch_flag), .ovf_flag(ovf_flag)
  );

  localparam logic [7:0] CH_HIGH = 8'h28;
  localparam logic [7:0] CH_LOW  = 8'h24;

  function automatic logic exp_level(int c, int d, bit lowt);
    return (c < d) ^ lowt;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(output int c);
    logic [7:0] h;
    bus_addr = 3'd6; #1 h = bus_rdata;
    bus_addr = 3'd7; #1 c = {h, bus_rdata};
  endtask

  task automatic wait_cnt(input int v);
    int c;
    int guard = 0;
    peek(c);
    while (c != v && guard < 100) begin
      @(negedge clk); peek(c); guard++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; dbg_mode = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(input int lim, input int duty, input logic [7:0] ch);
    wr(3'd1, 8'(lim >> 8)); wr(3'd2, 8'(lim));
    wr(3'd4, 8'(duty >> 8)); wr(3'd5, 8'(duty));
    wr(3'd3, ch);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int c, n, seed;
    seed = $urandom(32'h5eed);
    do_reset();

    // R1 reset state
    check("R1 pin", pwm_out, 0);
    check("R1 flags", {ch_flag, ovf_flag}, 0);
    rd(3'd0, r); check("R1 ctrl", r, 8'h00);
    rd(3'd3, r); check("R1 chctl", r, 8'h00);
    rd(3'd1, r); check("R1 limit hi", r, 8'hFF);
    rd(3'd2, r); check("R1 limit lo", r, 8'hFF);
    rd(3'd5, r); check("R1 duty lo", r, 8'h00);

    // R6 pair staging, low byte first, clock stopped
    wr(3'd5, 8'h03);
    repeat (2) @(negedge clk);
    rd(3'd5, r); check("R6 half pair not applied", r, 8'h00);
    wr(3'd4, 8'h01);
    @(negedge clk);
    rd(3'd5, r); check("R6 duty lo", r, 8'h03);
    rd(3'd4, r); check("R6 duty hi", r, 8'h01);

    // R7 debug-mode control write drops half of limit
    wr(3'd1, 8'h00);
    dbg_mode = 1'b1; wr(3'd0, 8'h00); dbg_mode = 1'b0;
    wr(3'd2, 8'h07);
    repeat (2) @(negedge clk);
    rd(3'd2, r); check("R7 half dropped", r, 8'hFF);
    wr(3'd1, 8'h00);
    @(negedge clk);
    rd(3'd2, r); check("R7 new pair lo", r, 8'h07);
    rd(3'd1, r); check("R7 new pair hi", r, 8'h00);
    wr(3'd1, 8'h00); wr(3'd0, 8'h00); wr(3'd2, 8'h05);
    @(negedge clk);
    rd(3'd2, r); check("R7 no debug keeps half", r, 8'h05);

    // R2 period and R8 high-true levels, limit 7 duty 5
    do_reset();
    setup(7, 5, CH_HIGH);
    wr(3'd0, 8'h01);
    wait_cnt(0); n = 0;
    do begin
      @(negedge clk); peek(c); n++;
      check("R8 high-true level", pwm_out, exp_level(c, 5, 0));
    end while (c != 0 && n < 50);
    check("R2 period length", n, 8);

    // R3 mid-period duty change
    wait_cnt(2);
    wr(3'd4, 8'h00); wr(3'd5, 8'h02);
    peek(c); check("R3 count at check", c, 4);
    check("R3 old duty kept", pwm_out, 1);
    wait_cnt(0); check("R3 new period start", pwm_out, 1);
    wait_cnt(1); check("R3 new duty count1", pwm_out, 1);
    wait_cnt(2); check("R3 new duty count2", pwm_out, 0);

    // R4 change to zero
    do_reset();
    setup(7, 5, CH_HIGH);
    wr(3'd0, 8'h01);
    wait_cnt(1);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wait_cnt(4); check("R4 old duty finishes", pwm_out, 1);
    wait_cnt(0); check("R4 zero next period c0", pwm_out, 0);
    wait_cnt(3); check("R4 zero next period c3", pwm_out, 0);

    // R5 freeze
    do_reset();
    setup(7, 5, CH_HIGH);
    wr(3'd0, 8'h01);
    wait_cnt(3);
    wr(3'd0, 8'h00);
    repeat (10) @(negedge clk);
    peek(c); check("R5 counter held", c, 4);
    check("R5 pin held", pwm_out, 1);
    wr(3'd3, CH_LOW);
    repeat (3) @(negedge clk);
    check("R5 control write no change", pwm_out, 1);
    wr(3'd0, 8'h01);
    wait_cnt(0); check("R8 low-true at count0", pwm_out, 0);
    wait_cnt(6); check("R8 low-true at count6", pwm_out, 1);

    // R8 disabled polarity drives 0
    wr(3'd3, 8'h20);
    repeat (3) @(negedge clk);
    check("R8 polarity 00 drives 0", pwm_out, 0);

    // R9 extremes
    do_reset();
    setup(7, 0, CH_HIGH);
    wr(3'd0, 8'h01);
    n = 0;
    repeat (16) begin @(negedge clk); n += pwm_out; end
    check("R9 zero duty", n, 0);
    do_reset();
    setup(7, 9, CH_HIGH);
    wr(3'd0, 8'h01);
    @(negedge clk);
    n = 0;
    repeat (16) begin @(negedge clk); n += pwm_out; end
    check("R9 duty above limit", n, 16);

    // R10 R11 flag set and clear protocol
    do_reset();
    setup(7, 5, CH_HIGH);
    wr(3'd0, 8'h01);
    repeat (20) @(negedge clk);
    wr(3'd0, 8'h00);
    rd(3'd0, r); check("R11 write without read keeps flag", r, 8'h80);
    wr(3'd0, 8'h00);
    rd(3'd0, r); check("R11 read then write clears", r, 8'h00);
    wr(3'd3, CH_HIGH);
    rd(3'd3, r); check("R10 write without read keeps flag", r, 8'hA8);
    wr(3'd3, CH_HIGH);
    rd(3'd3, r); check("R10 read then write clears", r, 8'h28);

    // random configurations, R2 and R8
    for (int it = 0; it < 12; it++) begin
      int m, d;
      bit lowt;
      m = 1 + int'($urandom % 30);
      d = int'($urandom % (m + 3));
      lowt = 1'($urandom % 2);
      do_reset();
      setup(m, d, lowt ? CH_LOW : CH_HIGH);
      wr(3'd0, 8'h01);
      repeat (3 * (m + 1)) begin
        @(negedge clk); peek(c);
        check("R8 random level", pwm_out, exp_level(c, d, lowt));
        check("R2 random count in range", (c <= m) ? 1 : 0, 1);
      end
    end

    done = 1'b1;
    report();
    $finish;
  end
endmodule